// File: doc/BRIEF.md
# Serial Boot Flash Command Engine

This block is a host-side SPI master that talks to a serial boot flash through a small byte-wide register window. Software loads an opcode, up to two address bytes and up to four payload bytes into the window, then writes a mode byte. The high nibble of that mode byte picks one of eleven fixed transaction shapes and starts the transfer. The low nibble supplies the top of the flash address.

The engine drives chip select low and shifts out the opcode, the address, an optional dummy byte and the write payload. It then clocks in any read bytes and stores them back into the payload registers. A status register shows whether a transfer is running and whether the last mode write was rejected. Only the fixed shapes exist. There is no free byte count.

The address carries only four bits above the two address registers. Those four bits become address bits 19:16 of the 24-bit address on the wire, and bits 23:20 are always sent as zero. The reachable space is therefore 1 MiB (8 Mbit).

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset the status register (offset 8) reads 0x00, chip select is high, SCK is low, the opcode register (offset 0) reads 0x00 and the divider register (offset 9) reads 0x01.
- R2: Each frame is sent in this order: the opcode (offset 0). Then, for addressed shapes, three address bytes: {4'h0, mode[3:0]}, offset 2, offset 3. Then a 0x00 dummy byte for shape 7. Then the write bytes, taken from offset 4 upward.
- R3: The mode high nibble selects the frame length as (address, dummy, write, read) bytes:
  - 1 = (0,0,0,0)
  - 2 = (0,0,1,0)
  - 3 = (0,0,0,2)
  - 4 = (3,0,0,0)
  - 5 = (3,0,1,0)
  - 6 = (3,0,4,0)
  - 7 = (3,1,0,4)
  - 8..B = (3,0,0,code-7)
  
  Each byte is eight SCK pulses.
- R4: The read bytes of a frame are stored, in the order received, into offsets 4, 5, 6 and so on. Payload registers beyond the read count keep their value.
- R5: A mode write whose high nibble is 0 or above 0xB produces no chip-select activity. It leaves the mode register unchanged and sets status bit 1. The next accepted mode write clears that bit.
- R6: SPI runs in mode 0, MSB first. SCK idles low while chip select is high, and chip select stays low from the first bit to the last.
- R7: The SCK half period is (divider + 1) clock cycles, where the divider is offset 9.
- R8: Status bit 0 (busy) reads 1 from the cycle after an accepted mode write until chip select has returned high. While busy, writes to offsets 0 to 9 are ignored.
- R9: A register read returns its data on bus_rdata one clock after bus_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data for bus_addr |
| busy | output | 1 | Transfer pending or running |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
Two events can land in the same cycle. A software register write can arrive in the one cycle where the launch is accepted but the shifter has not yet started. A write can also arrive while the last read byte is being stored back as the frame closes. The bench provokes the first case by writing the opcode register on the clock right after the mode write. It then updates the payload and divider registers while busy. It judges the outcome from what the flash model captured on MOSI and from the register read-back after completion: the old opcode, the old payload and the old divider must all survive, and the SCK spacing must match the old divider.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int NDATA   = 4;
  localparam int IDX_W   = $clog2(NDATA);
  localparam int FRAME_N = 1 + 3 + 1 + NDATA;
  localparam int CNT_W   = $clog2(FRAME_N + 1);

  localparam logic [3:0] OFS_OP   = 4'd0;
  localparam logic [3:0] OFS_MODE = 4'd1;
  localparam logic [3:0] OFS_AMID = 4'd2;
  localparam logic [3:0] OFS_ALO  = 4'd3;
  localparam logic [3:0] OFS_STAT = 4'd8;
  localparam logic [3:0] OFS_DIV  = 4'd9;

  typedef logic [FRAME_N-1:0][7:0] frame_t;

  typedef struct packed {
    logic       ok;
    logic       has_addr;
    logic       dummy;
    logic [2:0] nwr;
    logic [2:0] nrd;
  } shape_t;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_TAIL} shift_st_t;

  function automatic shape_t decode_shape(input logic [3:0] code);
    shape_t s;
    s = '0;
    s.ok = 1'b1;
    case (code)
      4'h1: ;
      4'h2: s.nwr = 3'd1;
      4'h3: s.nrd = 3'd2;
      4'h4: s.has_addr = 1'b1;
      4'h5: begin s.has_addr = 1'b1; s.nwr = 3'd1; end
      4'h6: begin s.has_addr = 1'b1; s.nwr = 3'd4; end
      4'h7: begin s.has_addr = 1'b1; s.dummy = 1'b1; s.nrd = 3'd4; end
      4'h8, 4'h9, 4'hA, 4'hB: begin
        s.has_addr = 1'b1;
        s.nrd = 3'(code - 4'd7);
      end
      default: s.ok = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic [3:0]            bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic                  engine_busy,
  input  logic                  rx_we,
  input  logic [IDX_W-1:0]      rx_idx,
  input  logic [7:0]            rx_byte,
  output logic [7:0]            op_q,
  output logic [7:0]            mode_q,
  output logic [7:0]            amid_q,
  output logic [7:0]            alo_q,
  output logic [NDATA-1:0][7:0] data_q,
  output logic [DIV_W-1:0]      div_q,
  output logic                  launch,
  output logic                  busy_all
);
  logic   err_q;
  shape_t wshape;

  assign busy_all = engine_busy | launch;
  assign wshape   = decode_shape(bus_wdata[7:4]);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      mode_q <= '0;
      amid_q <= '0;
      alo_q  <= '0;
      data_q <= '0;
      div_q  <= DIV_W'(DIV_RST);
      launch <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (bus_we && !busy_all) begin
        case (bus_addr)
          OFS_OP:   op_q   <= bus_wdata;
          OFS_MODE: begin
            if (wshape.ok) begin
              mode_q <= bus_wdata;
              launch <= 1'b1;
              err_q  <= 1'b0;
            end else begin
              err_q  <= 1'b1;
            end
          end
          OFS_AMID: amid_q <= bus_wdata;
          OFS_ALO:  alo_q  <= bus_wdata;
          4'd4, 4'd5, 4'd6, 4'd7: data_q[bus_addr[IDX_W-1:0]] <= bus_wdata;
          OFS_DIV:  div_q  <= DIV_W'(bus_wdata);
          default: ;
        endcase
      end
      if (rx_we) data_q[rx_idx] <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFS_OP:   bus_rdata <= op_q;
        OFS_MODE: bus_rdata <= mode_q;
        OFS_AMID: bus_rdata <= amid_q;
        OFS_ALO:  bus_rdata <= alo_q;
        4'd4, 4'd5, 4'd6, 4'd7: bus_rdata <= data_q[bus_addr[IDX_W-1:0]];
        OFS_STAT: bus_rdata <= {6'd0, err_q, busy_all};
        OFS_DIV:  bus_rdata <= 8'(div_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_frame.sv
module flash_cmd_frame
  import flash_cmd_pkg::*;
(
  input  logic [7:0]            op_q,
  input  logic [7:0]            mode_q,
  input  logic [7:0]            amid_q,
  input  logic [7:0]            alo_q,
  input  logic [NDATA-1:0][7:0] data_q,
  output frame_t                tx,
  output logic [CNT_W-1:0]      n_tx,
  output logic [CNT_W-1:0]      n_total
);
  shape_t sh;
  assign sh = decode_shape(mode_q[7:4]);

  always_comb begin
    int k;
    tx    = '0;
    tx[0] = op_q;
    k     = 1;
    if (sh.has_addr) begin
      tx[1] = {4'h0, mode_q[3:0]};
      tx[2] = amid_q;
      tx[3] = alo_q;
      k     = 4;
    end
    if (sh.dummy) begin
      tx[k] = 8'h00;
      k     = k + 1;
    end
    for (int i = 0; i < NDATA; i++) begin
      if (i < int'(sh.nwr)) tx[k + i] = data_q[i];
    end
    n_tx    = CNT_W'(k) + CNT_W'(sh.nwr);
    n_total = CNT_W'(k) + CNT_W'(sh.nwr) + CNT_W'(sh.nrd);
  end
endmodule

// File: rtl/flash_cmd_shifter.sv
module flash_cmd_shifter
  import flash_cmd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [DIV_W-1:0]   div,
  input  frame_t             tx,
  input  logic [CNT_W-1:0]   n_tx,
  input  logic [CNT_W-1:0]   n_total,
  input  logic               spi_miso,
  output logic               spi_sck,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  output logic               busy,
  output logic               rx_we,
  output logic [IDX_W-1:0]   rx_idx,
  output logic [7:0]         rx_byte
);
  shift_st_t        st;
  logic [DIV_W-1:0] hcnt;
  logic [2:0]       bitc;
  logic [CNT_W-1:0] bytec, nxt;
  logic [7:0]       shreg, rxsh;

  assign nxt  = bytec + CNT_W'(1);
  assign busy = (st != SH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SH_IDLE;
      spi_sck  <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_mosi <= 1'b0;
      hcnt     <= '0;
      bitc     <= '0;
      bytec    <= '0;
      shreg    <= '0;
      rxsh     <= '0;
      rx_we    <= 1'b0;
      rx_idx   <= '0;
      rx_byte  <= '0;
    end else begin
      rx_we <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (start) begin
            st       <= SH_SHIFT;
            spi_cs_n <= 1'b0;
            hcnt     <= '0;
            bitc     <= '0;
            bytec    <= '0;
            shreg    <= tx[0];
            spi_mosi <= tx[0][7];
          end
        end
        SH_SHIFT: begin
          if (hcnt == div) begin
            hcnt <= '0;
            if (!spi_sck) begin
              spi_sck <= 1'b1;
              rxsh    <= {rxsh[6:0], spi_miso};
            end else begin
              spi_sck <= 1'b0;
              if (bitc == 3'd7) begin
                bitc <= '0;
                if (bytec >= n_tx) begin
                  rx_we   <= 1'b1;
                  rx_idx  <= IDX_W'(bytec - n_tx);
                  rx_byte <= rxsh;
                end
                if (nxt == n_total) begin
                  st       <= SH_TAIL;
                  spi_mosi <= 1'b0;
                end else begin
                  bytec    <= nxt;
                  shreg    <= tx[nxt];
                  spi_mosi <= tx[nxt][7];
                end
              end else begin
                bitc     <= bitc + 3'd1;
                shreg    <= {shreg[6:0], 1'b0};
                spi_mosi <= shreg[6];
              end
            end
          end else begin
            hcnt <= hcnt + DIV_W'(1);
          end
        end
        SH_TAIL: begin
          if (hcnt == div) begin
            spi_cs_n <= 1'b1;
            st       <= SH_IDLE;
          end else begin
            hcnt <= hcnt + DIV_W'(1);
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       busy,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [7:0]            op_q, mode_q, amid_q, alo_q;
  logic [NDATA-1:0][7:0] data_q;
  logic [DIV_W-1:0]      div_q;
  logic                  launch, engine_busy, rx_we;
  logic [IDX_W-1:0]      rx_idx;
  logic [7:0]            rx_byte;
  frame_t                tx;
  logic [CNT_W-1:0]      n_tx, n_total;

  flash_cmd_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .engine_busy(engine_busy),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .op_q(op_q), .mode_q(mode_q), .amid_q(amid_q), .alo_q(alo_q),
    .data_q(data_q), .div_q(div_q), .launch(launch), .busy_all(busy)
  );

  flash_cmd_frame u_frame (
    .op_q(op_q), .mode_q(mode_q), .amid_q(amid_q), .alo_q(alo_q),
    .data_q(data_q), .tx(tx), .n_tx(n_tx), .n_total(n_total)
  );

  flash_cmd_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .start(launch), .div(div_q), .tx(tx),
    .n_tx(n_tx), .n_total(n_total), .spi_miso(spi_miso),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .busy(engine_busy), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             busy,
  input logic             spi_sck,
  input logic             spi_cs_n,
  input logic [7:0]       op_q,
  input logic [DIV_W-1:0] div_q
);
  logic [DIV_W:0] hp_cnt;
  logic           mode_wr_idle, mode_ok;

  assign mode_wr_idle = bus_we && (bus_addr == 4'd1) && !busy;
  assign mode_ok      = (bus_wdata[7:4] != 4'h0) && (bus_wdata[7:4] <= 4'hB);

  always_ff @(posedge clk) begin
    if (rst) hp_cnt <= '0;
    else if ((spi_sck != $past(spi_sck)) || $fell(spi_cs_n)) hp_cnt <= '0;
    else if (!spi_cs_n) hp_cnt <= hp_cnt + 1'b1;
  end

  assert_cs_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);

  assert_sck_rest_R6: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  assert_half_period_R7: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && (spi_sck != $past(spi_sck))) |-> (hp_cnt == (DIV_W+1)'(div_q)));

  assert_bad_mode_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_wr_idle && !mode_ok) |=> !busy);

  assert_launch_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_wr_idle && mode_ok) |=> busy);

  assert_op_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == 4'd0) |=> $stable(op_q));

  assert_div_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == 4'd9) |=> $stable(div_q));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy), .spi_sck(spi_sck),
  .spi_cs_n(spi_cs_n), .op_q(op_q), .div_q(div_q)
);

// File: tb/flash_cmd_engine_bench.sv
module flash_cmd_engine_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       busy, spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  flash_cmd_engine u_flash_cmd_engine (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // flash model
  function automatic logic [7:0] resp_byte(input int i);
    return (8'(i) * 8'h1D) ^ 8'hC3;
  endfunction

  logic [7:0] cap [16];
  logic [7:0] shin = '0;
  logic [7:0] cur;
  int   bitn = 0;
  int   frames = 0;
  logic cs_prev = 1'b1, sck_prev = 1'b0;
  time  t_r0, t_r1;

  always @(spi_sck, spi_cs_n) begin
    if (spi_cs_n !== cs_prev && spi_cs_n === 1'b0) begin
      bitn = 0;
      frames++;
    end else if (spi_cs_n === 1'b0 && spi_sck === 1'b1 && sck_prev === 1'b0) begin
      if (bitn == 0) t_r0 = $time;
      if (bitn == 1) t_r1 = $time;
      shin = {shin[6:0], spi_mosi};
      if ((bitn % 8) == 7 && bitn < 128) cap[bitn / 8] = shin;
      bitn++;
    end
    cs_prev  = spi_cs_n;
    sck_prev = spi_sck;
  end

  always @* begin
    cur      = resp_byte(bitn >> 3);
    spi_miso = cur[7 - (bitn & 7)];
  end

  // bus helpers
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'h01;
    for (int n = 0; n < 2000 && s[0]; n++) rd(4'd8, s);
  endtask

  // expected shape (address bytes, dummy, write count, read count)
  task automatic shape_of(input logic [3:0] c, output int na, output int dm,
                          output int nw, output int nr);
    na = 3; dm = 0; nw = 0; nr = 0;
    case (c)
      4'h1: na = 0;
      4'h2: begin na = 0; nw = 1; end
      4'h3: begin na = 0; nr = 2; end
      4'h4: ;
      4'h5: nw = 1;
      4'h6: nw = 4;
      4'h7: begin dm = 1; nr = 4; end
      default: nr = int'(c) - 7;
    endcase
  endtask

  // stimulus table: mode, opcode, addr mid, addr low, payload (offset 4 in bits 31:24)
  localparam logic [63:0] VEC [11] = '{
    64'h10_06_00_00_00000000,
    64'h20_01_00_00_02AA55FF,
    64'h30_90_00_00_11111111,
    64'h45_20_12_34_00000000,
    64'h5A_02_56_78_AB000000,
    64'h6F_02_9A_BC_11223344,
    64'h73_0B_10_20_CAFEBABE,
    64'h81_03_00_10_99887766,
    64'h92_03_40_00_55667788,
    64'hA4_03_FF_FF_01020304,
    64'hB7_03_0A_0B_F0E0D0C0
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] expb [16];
    int na, dm, nw, nr, ntx, f0, mism;

    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 / R9 reset state
    rd(4'd8, r); chk("R1 status", r, 8'h00);
    chk("R1 cs_n", spi_cs_n, 1'b1);
    chk("R1 sck", spi_sck, 1'b0);
    rd(4'd0, r); chk("R1 opcode", r, 8'h00);
    rd(4'd9, r); chk("R1 divider", r, 8'h01);
    wr(4'd2, 8'h3C); rd(4'd2, r); chk("R9 readback", r, 8'h3C);

    // table walk: every shape
    for (int v = 0; v < 11; v++) begin
      logic [63:0] e;
      logic [7:0]  m;
      e = VEC[v];
      m = e[63:56];
      wr(4'd0, e[55:48]); wr(4'd2, e[47:40]); wr(4'd3, e[39:32]);
      for (int j = 0; j < 4; j++) wr(4'(4 + j), e[31 - 8*j -: 8]);
      f0 = frames;
      wr(4'd1, m);
      wait_idle();
      shape_of(m[7:4], na, dm, nw, nr);
      ntx = 0;
      expb[ntx++] = e[55:48];
      if (na == 3) begin
        expb[ntx++] = {4'h0, m[3:0]};
        expb[ntx++] = e[47:40];
        expb[ntx++] = e[39:32];
      end
      if (dm == 1) expb[ntx++] = 8'h00;
      for (int j = 0; j < nw; j++) expb[ntx++] = e[31 - 8*j -: 8];
      chk("R3 sck pulses", 32'(bitn), 32'(8 * (ntx + nr)));
      mism = 0;
      for (int j = 0; j < ntx; j++) if (cap[j] !== expb[j]) mism++;
      chk("R2 frame bytes", 32'(mism), 0);
      chk("R6 single frame", 32'(frames - f0), 1);
      for (int j = 0; j < 4; j++) begin
        rd(4'(4 + j), r);
        chk("R4 payload reg", r, (j < nr) ? resp_byte(ntx + j) : e[31 - 8*j -: 8]);
      end
    end

    // R5 rejected modes
    rd(4'd1, r);
    f0 = frames;
    wr(4'd1, 8'hC2);
    repeat (10) @(negedge clk);
    chk("R5 no frame for C", 32'(frames - f0), 0);
    rd(4'd8, r); chk("R5 err set", r, 8'h02);
    wr(4'd1, 8'h05);
    repeat (10) @(negedge clk);
    chk("R5 no frame for 0", 32'(frames - f0), 0);
    rd(4'd1, r); chk("R5 mode kept", r, 8'hB7);
    wr(4'd0, 8'h06); wr(4'd1, 8'h10);
    wait_idle();
    rd(4'd8, r); chk("R5 err cleared", r, 8'h00);

    // R7 / R8: divider, writes during pending launch and busy
    wr(4'd9, 8'h03);
    wr(4'd0, 8'h02); wr(4'd2, 8'h00); wr(4'd3, 8'h40);
    wr(4'd4, 8'hA1); wr(4'd5, 8'hA2); wr(4'd6, 8'hA3); wr(4'd7, 8'hA4);
    @(negedge clk); bus_we = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h61;
    @(negedge clk); bus_addr = 4'd0; bus_wdata = 8'hEE;
    @(negedge clk); bus_we = 1'b0;
    rd(4'd8, r); chk("R8 busy bit", r, 8'h01);
    wr(4'd4, 8'h55);
    wr(4'd9, 8'h00);
    wait_idle();
    rd(4'd0, r); chk("R8 opcode kept", r, 8'h02);
    rd(4'd4, r); chk("R8 payload kept", r, 8'hA1);
    rd(4'd9, r); chk("R8 divider kept", r, 8'h03);
    chk("R8 frame opcode", cap[0], 8'h02);
    chk("R2 frame top addr", cap[1], 8'h01);
    chk("R7 sck period", 32'(t_r1 - t_r0), 32'(2 * 4 * 4));
    chk("R6 sck idle", spi_sck, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule